// File: doc/BRIEF.md
# Sequential FIR Filter Accelerator with Register Control

This block is a single-channel, 59-tap FIR filter that produces one output sample per run, with each run started by software. A processor talks to it over an AXI4-Lite slave port. To filter one sample, software writes the sample, writes the start bit, and then waits. It can wait by polling the status bits or by taking the completion interrupt. It then reads the filtered result and its valid flag.

Inside the block there is a 59-entry delay line of past inputs and a fixed coefficient set computed at elaboration. A single multiply-accumulate unit walks the taps one per clock. A small register file holds control, status and interrupt state. Because there is only one multiplier, a run takes 60 clocks. In exchange the datapath stays one multiplier and one 38-bit adder wide.

Top module: `fir_seq_accel`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x4, and the valid flag (0x1C), the output (0x18) and the interrupt status (0x0C) read 0. The irq pin is low and every delay-line entry is zero.
- R2: A write is accepted only when address and data are valid together. It is answered with bresp 0 (OKAY), and every read is answered with rresp 0. At most one write response and one read response are outstanding.
- R3: Writing 1 to bit 0 of offset 0x00 (with wstrb bit 0 set) while idle starts a run. The delay line shifts by one place and bits 15:0 of the sample register (offset 0x10) enter the newest position. Writing 0 to that bit starts nothing.
- R4: Completion (done, valid, interrupt status) becomes visible exactly 60 clock cycles after the clock edge on which the start write is accepted.
- R5: The result is the 38-bit signed sum of x[n-k]*c[k] over k = 0..58, shifted right arithmetically by 15 and saturated to [-32768, 32767]. It reads at offset 0x18, sign-extended to 32 bits.
- R6: The coefficients are c[0] = -32768 and c[k] = ((2731*k + 517) mod 20011) - 10005 for k = 1..58. A 0x8000 impulse followed by zeros therefore yields 32767 first (saturated) and then -c[k].
- R7: A start written while a run is in progress is ignored. The run continues unchanged and the delay line does not shift a second time.
- R8: Offset 0x00 reads bit 0 = busy, bit 1 = done and bit 2 = idle. Done is set on completion and cleared by a read of 0x00.
- R9: Bit 0 of offset 0x1C is set on completion and cleared by a read of 0x1C.
- R10: Bit 0 of offset 0x0C is set on completion and cleared by writing 1. The irq pin is the AND of bit 0 of 0x04 (global enable), bit 0 of 0x08 (enable) and that status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 5 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 5 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Completion interrupt |

## Verification
The bench drives a 0x8000 impulse through all 59 taps and one step beyond. A wrong coefficient, an operand that is not sign-extended, or a missing saturation shows up directly as a wrong output. The first output must clip to 32767, and a design that wraps would return -32768 instead. It measures the cycles from the start handshake to the interrupt, so an off-by-one in the tap counter or a missing final stage changes the count away from 60. It issues a second start in the middle of a run and then checks the following result against a one-shift model; a design that honours that start would shift the delay line twice. It also checks that done and valid clear on read and that status stays pending while the global enable is off, so that the irq pin rises as soon as the enable returns.

// File: rtl/fir_accel_pkg.sv
package fir_accel_pkg;

    localparam int TAPS   = 59;
    localparam int SMP_W  = 16;
    localparam int ACC_W  = 38;
    localparam int FRAC   = 15;
    localparam int BUS_DW = 32;

    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_GIE  = 5'h04;
    localparam logic [4:0] OFF_IER  = 5'h08;
    localparam logic [4:0] OFF_ISR  = 5'h0C;
    localparam logic [4:0] OFF_XIN  = 5'h10;
    localparam logic [4:0] OFF_YOUT = 5'h18;
    localparam logic [4:0] OFF_YVLD = 5'h1C;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mac_state_e;

    // Fixed coefficient set: tap 0 at full negative scale, the rest from a
    // modular sequence spread over roughly +/-10000.
    function automatic logic signed [15:0] coef_at(input int k);
        int v;
        if (k == 0) v = -32768;
        else        v = ((k * 2731 + 517) % 20011) - 10005;
        return v[15:0];
    endfunction

endpackage

// File: rtl/fir_mac_core.sv
module fir_mac_core
    import fir_accel_pkg::*;
#(
    parameter int N_TAPS = TAPS,
    parameter int DW     = SMP_W,
    parameter int ACCW   = ACC_W,
    parameter int SHIFT  = FRAC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] sample_i,
    output logic          idle_o,
    output logic          done_o,
    output logic [DW-1:0] result_o
);

    localparam int IW = $clog2(N_TAPS);
    localparam logic [IW-1:0] LAST = IW'(N_TAPS - 1);
    localparam logic signed [ACCW-1:0] YMAX = ACCW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] YMIN = -YMAX - 1;

    typedef struct packed {
        mac_state_e                  st;
        logic [IW-1:0]               idx;
        logic signed [ACCW-1:0]      acc;
        logic [N_TAPS-1:0][DW-1:0]   line;
    } mac_t;

    mac_t q, d;
    logic signed [ACCW-1:0] tap_x, tap_c, prod, scaled;

    always_comb begin
        d     = q;
        tap_x = ACCW'($signed(q.line[q.idx]));
        tap_c = ACCW'(coef_at(int'(q.idx)));
        prod  = tap_x * tap_c;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.line = {q.line[N_TAPS-2:0], sample_i};
                    d.acc  = '0;
                    d.idx  = '0;
                    d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                d.acc = q.acc + prod;
                if (q.idx == LAST) d.st  = ST_FIN;
                else               d.idx = q.idx + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase

        scaled = q.acc >>> SHIFT;
        if (scaled > YMAX)      result_o = YMAX[DW-1:0];
        else if (scaled < YMIN) result_o = YMIN[DW-1:0];
        else                    result_o = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle_o = (q.st == ST_IDLE);
    assign done_o = (q.st == ST_FIN);

    // R4: the last tap is followed directly by completion
    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.idx == LAST) |=> done_o);

    // R3: taps are visited in order, one per clock
    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && q.idx != LAST) |=> (q.st == ST_RUN && q.idx == $past(q.idx) + 1'b1));

    // R7: a start during a run does not disturb the delay line
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !idle_o) |=> $stable(q.line));

    // R8: completion returns the engine to idle
    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> idle_o);

endmodule

// File: rtl/fir_axil_regs.sv
module fir_axil_regs
    import fir_accel_pkg::*;
#(
    parameter int DW = BUS_DW,
    parameter int SW = SMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    awaddr,
    input  logic          awvalid,
    output logic          awready,
    input  logic [DW-1:0] wdata,
    input  logic [DW/8-1:0] wstrb,
    input  logic          wvalid,
    output logic          wready,
    output logic [1:0]    bresp,
    output logic          bvalid,
    input  logic          bready,
    input  logic [4:0]    araddr,
    input  logic          arvalid,
    output logic          arready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp,
    output logic          rvalid,
    input  logic          rready,
    output logic          irq_o,
    output logic          start_o,
    output logic [SW-1:0] sample_o,
    input  logic          idle_i,
    input  logic          done_i,
    input  logic [SW-1:0] result_i
);

    typedef struct packed {
        logic          bvalid;
        logic          rvalid;
        logic [DW-1:0] rdata;
        logic          gie;
        logic          ier;
        logic          isr;
        logic          done;
        logic          yvld;
        logic [SW-1:0] xin;
        logic [SW-1:0] yout;
    } reg_t;

    reg_t q, d;
    logic wr, rd;

    always_comb begin
        d       = q;
        wr      = awvalid && wvalid && !q.bvalid;
        rd      = arvalid && !q.rvalid;
        start_o = wr && (awaddr == OFF_CTRL) && wstrb[0] && wdata[0] && idle_i;

        if (q.bvalid && bready) d.bvalid = 1'b0;
        if (wr) begin
            d.bvalid = 1'b1;
            case (awaddr)
                OFF_GIE: if (wstrb[0]) d.gie = wdata[0];
                OFF_IER: if (wstrb[0]) d.ier = wdata[0];
                OFF_ISR: if (wstrb[0] && wdata[0]) d.isr = 1'b0;
                OFF_XIN: begin
                    for (int b = 0; b < SW / 8; b++)
                        if (wstrb[b]) d.xin[8*b +: 8] = wdata[8*b +: 8];
                end
                default: ;
            endcase
        end

        if (q.rvalid && rready) d.rvalid = 1'b0;
        if (rd) begin
            d.rvalid = 1'b1;
            case (araddr)
                OFF_CTRL: begin
                    d.rdata = {{(DW-3){1'b0}}, idle_i, q.done, !idle_i};
                    d.done  = 1'b0;
                end
                OFF_GIE:  d.rdata = {{(DW-1){1'b0}}, q.gie};
                OFF_IER:  d.rdata = {{(DW-1){1'b0}}, q.ier};
                OFF_ISR:  d.rdata = {{(DW-1){1'b0}}, q.isr};
                OFF_XIN:  d.rdata = {{(DW-SW){1'b0}}, q.xin};
                OFF_YOUT: d.rdata = DW'($signed(q.yout));
                OFF_YVLD: begin
                    d.rdata = {{(DW-1){1'b0}}, q.yvld};
                    d.yvld  = 1'b0;
                end
                default:  d.rdata = '0;
            endcase
        end

        // completion outranks a same-cycle clear
        if (done_i) begin
            d.done = 1'b1;
            d.yvld = 1'b1;
            d.isr  = 1'b1;
            d.yout = result_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign awready  = awvalid && wvalid && !q.bvalid;
    assign wready   = awready;
    assign bvalid   = q.bvalid;
    assign bresp    = 2'b00;
    assign arready  = !q.rvalid;
    assign rvalid   = q.rvalid;
    assign rdata    = q.rdata;
    assign rresp    = 2'b00;
    assign sample_o = q.xin;
    assign irq_o    = q.gie && q.ier && q.isr;

    // R2: responses hold until taken
    p_bresp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R10: status only rises on a completion from the engine
    p_isr_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.isr) |-> $past(done_i));

    // R9: the valid flag only rises on a completion
    p_valid_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.yvld) |-> $past(done_i));

endmodule

// File: rtl/fir_seq_accel.sv
module fir_seq_accel
    import fir_accel_pkg::*;
(
    input  logic        aclk,
    input  logic        aresetn,
    input  logic [4:0]  s_awaddr,
    input  logic        s_awvalid,
    output logic        s_awready,
    input  logic [31:0] s_wdata,
    input  logic [3:0]  s_wstrb,
    input  logic        s_wvalid,
    output logic        s_wready,
    output logic [1:0]  s_bresp,
    output logic        s_bvalid,
    input  logic        s_bready,
    input  logic [4:0]  s_araddr,
    input  logic        s_arvalid,
    output logic        s_arready,
    output logic [31:0] s_rdata,
    output logic [1:0]  s_rresp,
    output logic        s_rvalid,
    input  logic        s_rready,
    output logic        irq
);

    logic             start_w, idle_w, done_w;
    logic [SMP_W-1:0] sample_w, result_w;

    fir_axil_regs #(.DW(BUS_DW), .SW(SMP_W)) u_regs (
        .clk      (aclk),
        .rst_n    (aresetn),
        .awaddr   (s_awaddr),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .wdata    (s_wdata),
        .wstrb    (s_wstrb),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .bresp    (s_bresp),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .araddr   (s_araddr),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .rdata    (s_rdata),
        .rresp    (s_rresp),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .irq_o    (irq),
        .start_o  (start_w),
        .sample_o (sample_w),
        .idle_i   (idle_w),
        .done_i   (done_w),
        .result_i (result_w)
    );

    fir_mac_core #(.N_TAPS(TAPS), .DW(SMP_W), .ACCW(ACC_W), .SHIFT(FRAC)) u_mac (
        .clk      (aclk),
        .rst_n    (aresetn),
        .start_i  (start_w),
        .sample_i (sample_w),
        .idle_o   (idle_w),
        .done_o   (done_w),
        .result_o (result_w)
    );

endmodule

// File: tb/sim_fir_seq_accel.sv
`timescale 1ns/1ps
module sim_fir_seq_accel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    always #2.5 clk = ~clk;

    fir_seq_accel u0 (
        .aclk(clk), .aresetn(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .irq(irq)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int hist[59];
    int unsigned hs_cyc;

    function automatic int coef_ref(input int k);
        if (k == 0) return -32768;
        return ((k * 2731 + 517) % 20011) - 10005;
    endfunction

    function automatic int model_out();
        longint acc = 0;
        longint s;
        for (int k = 0; k < 59; k++) acc += longint'(hist[k]) * longint'(coef_ref(k));
        s = acc >>> 15;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    function automatic void push(input int x);
        for (int k = 58; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] v, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = v; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!(awready && wready)) begin @(negedge clk); #1; end
        hs_cyc = cyc + 1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; bready = 1'b1;
        #1;
        while (!bvalid) begin @(negedge clk); #1; end
        check("R2 bresp", longint'(bresp), 0);
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 1'b0; rready = 1'b1;
        #1;
        while (!rvalid) begin @(negedge clk); #1; end
        v = rdata;
        check("R2 rresp", longint'(rresp), 0);
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic wait_irq(output int unsigned lat);
        int g = 0;
        while (!irq && g < 500) begin @(negedge clk); g++; end
        lat = cyc - hs_cyc;
    endtask

    // read back and clear everything a completion leaves behind
    task automatic collect(input int exp_y);
        logic [31:0] v;
        bus_rd(5'h00, v); check("R8 ctrl done+idle", longint'(v), 6);
        bus_rd(5'h00, v); check("R8 done cleared by read", longint'(v), 4);
        bus_rd(5'h1C, v); check("R9 valid set", longint'(v), 1);
        bus_rd(5'h1C, v); check("R9 valid cleared by read", longint'(v), 0);
        bus_rd(5'h18, v); check("R5 R6 output", longint'($signed(v)), longint'(exp_y));
        bus_wr(5'h0C, 32'h1, 4'h1);
        @(negedge clk);
        check("R10 irq low after W1C", longint'(irq), 0);
    endtask

    task automatic run_one(input int x);
        int unsigned lat;
        bus_wr(5'h10, {16'h0, x[15:0]}, 4'b0011);
        bus_wr(5'h00, 32'h1, 4'h1);
        push(x);
        wait_irq(lat);
        check("R4 start-to-completion cycles", longint'(lat), 60);
        collect(model_out());
    endtask

    initial begin
        logic [31:0] v;
        int unsigned lat;
        int x;
        void'($urandom(32'd914207));
        foreach (hist[k]) hist[k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", longint'(irq), 0);
        bus_rd(5'h00, v); check("R1 ctrl idle", longint'(v), 4);
        bus_rd(5'h1C, v); check("R1 valid clear", longint'(v), 0);
        bus_rd(5'h18, v); check("R1 output zero", longint'(v), 0);
        bus_rd(5'h0C, v); check("R1 status clear", longint'(v), 0);

        bus_wr(5'h04, 32'h1, 4'h1);
        bus_wr(5'h08, 32'h1, 4'h1);

        // R6: impulse walks the coefficient set, then leaves the line
        run_one(-32768);
        for (int i = 0; i < 59; i++) run_one(0);

        // R5: random samples
        for (int i = 0; i < 30; i++) begin
            x = int'($urandom_range(0, 65535)) - 32768;
            run_one(x);
        end
        // full-scale positive run toward saturation
        for (int i = 0; i < 4; i++) run_one(32767);

        // R3: writing 0 to start does nothing
        bus_wr(5'h00, 32'h0, 4'h1);
        bus_rd(5'h00, v); check("R3 zero start keeps idle", longint'(v), 4);
        bus_rd(5'h1C, v); check("R3 zero start no result", longint'(v), 0);

        // R7: a start during a run is ignored
        x = int'($urandom_range(0, 65535)) - 32768;
        bus_wr(5'h10, {16'h0, x[15:0]}, 4'b0011);
        bus_wr(5'h00, 32'h1, 4'h1);
        lat = hs_cyc;
        push(x);
        bus_wr(5'h10, 32'h0000_1234, 4'b0011);
        bus_wr(5'h00, 32'h1, 4'h1);
        bus_rd(5'h00, v); check("R8 R7 ctrl busy during run", longint'(v), 1);
        hs_cyc = lat;
        wait_irq(lat);
        check("R7 R4 run not restarted", longint'(lat), 60);
        collect(model_out());
        x = int'($urandom_range(0, 65535)) - 32768;
        run_one(x);

        // R10: status pending while the global enable is off
        bus_wr(5'h04, 32'h0, 4'h1);
        x = 12345;
        bus_wr(5'h10, {16'h0, x[15:0]}, 4'b0011);
        bus_wr(5'h00, 32'h1, 4'h1);
        push(x);
        v = '0;
        for (int g = 0; g < 100 && v[1] == 1'b0; g++) bus_rd(5'h00, v);
        check("R8 done seen by polling", longint'(v), 6);
        check("R10 irq masked by global enable", longint'(irq), 0);
        bus_rd(5'h0C, v); check("R10 status pending", longint'(v), 1);
        bus_wr(5'h04, 32'h1, 4'h1);
        @(negedge clk);
        check("R10 irq on enable", longint'(irq), 1);
        bus_wr(5'h0C, 32'h1, 4'h1);
        @(negedge clk);
        check("R10 irq cleared", longint'(irq), 0);
        bus_rd(5'h18, v); check("R5 output after polling", longint'($signed(v)), longint'(model_out()));
        bus_rd(5'h1C, v); check("R9 valid after polling", longint'(v), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R4): cycles %0d, expected under %0d", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule